// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns a 32-bit virtual address and a 6-bit address-space tag into a physical address and a cacheable flag. The answer arrives one clock after the request. The three most significant address bits pick one of four regions. The low user half and the top kernel quarter are translated. The two middle kernel eighths bypass translation and map straight onto physical memory. One of those two is cacheable and the other is not.

Translation searches all 64 entries at once. Each entry carries a 20-bit virtual page, a 20-bit physical frame, an address-space tag, and four flags: valid, writable, uncached and global. Because entries carry the tag, a process switch only changes the tag on the lookup port, and nothing has to be flushed. When no entry matches, the block signals a miss and does nothing else. Software then fills an entry through a write port that takes a slot index and the full entry contents.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, every entry is invalid, and the first lookup to a translated region reports a miss.
- R2: An address whose bit 31 is 0 is translated. On a hit `rsp_paddr` is the entry's frame concatenated with address bits 11:0, and `rsp_cacheable` is the inverse of the entry's uncached flag.
- R3: An address with bits 31:29 = 100 gives a hit with `rsp_paddr` = the address with bits 31:29 cleared and `rsp_cacheable` = 1. No entry is needed.
- R4: An address with bits 31:29 = 101 gives a hit with the same physical mapping as R3 and `rsp_cacheable` = 0.
- R5: An address with bits 31:30 = 11 is translated in the same way as R2.
- R6: An entry matches only if it is valid, its page equals address bits 31:12, and either its tag equals `lk_asid` or its global flag is 1.
- R7: A translated lookup with no matching entry gives `rsp_miss` = 1, `rsp_hit` = 0, `rsp_paddr` = 0, `rsp_cacheable` = 0 and `rsp_mod_fault` = 0.
- R8: A store (`lk_store` = 1) that hits an entry whose writable flag is 0 gives `rsp_mod_fault` = 1 together with `rsp_hit` = 1. A load that hits the same entry, or a store that hits a writable entry, gives 0.
- R9: When several valid entries match, the result comes from the lowest-numbered one.
- R10: A lookup issued in the same cycle as a write sees the table as it was before the write. The write is visible from the next cycle onward.
- R11: Every lookup is answered exactly one cycle later with `rsp_valid` = 1. In a cycle with no lookup, `rsp_valid` falls to 0 and the result fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space tag of the current process |
| lk_store | input | 1 | Lookup is for a store |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Slot to write |
| wr_vpn | input | 20 | Virtual page of the new entry |
| wr_asid | input | 6 | Address-space tag of the new entry |
| wr_pfn | input | 20 | Physical frame of the new entry |
| wr_valid | input | 1 | Valid flag of the new entry |
| wr_writable | input | 1 | Write-permission flag of the new entry |
| wr_uncached | input | 1 | Uncached flag of the new entry |
| wr_global | input | 1 | Match-any-tag flag of the new entry |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is present |
| rsp_hit | output | 1 | Translation succeeded or was bypassed |
| rsp_miss | output | 1 | No matching entry; software must refill |
| rsp_mod_fault | output | 1 | Store hit a read-only entry |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | The access may be cached |

## Verification
The write port and the lookup port can act in the same cycle. The sharpest case is a write that creates the very page being looked up. It is provoked by driving a write to a fresh slot and a lookup of that page on the same edge. The result must be a miss, and a repeat of the lookup on the next cycle must hit. A second collision is a write that installs a duplicate at a higher slot, or clears the lower copy. After each such write the reference model decides which frame the lowest matching slot must supply.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    SEG_USER_MAP = 2'd0,
    SEG_KDIR_C   = 2'd1,
    SEG_KDIR_U   = 2'd2,
    SEG_KERN_MAP = 2'd3
  } seg_e;

  localparam int unsigned SEG_BITS = 3;

endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
  import tlb_pkg::*;
(
  input  logic [SEG_BITS-1:0] top_bits,
  output seg_e                seg,
  output logic                mapped
);

  always_comb begin
    if (!top_bits[2])            seg = SEG_USER_MAP;
    else if (top_bits[1])        seg = SEG_KERN_MAP;
    else if (top_bits[0])        seg = SEG_KDIR_U;
    else                         seg = SEG_KDIR_C;
    mapped = (seg == SEG_USER_MAP) || (seg == SEG_KERN_MAP);
  end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 6,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_valid,
  input  logic               wr_writable,
  input  logic               wr_uncached,
  input  logic               wr_global,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [PFN_W-1:0]   rd_pfn,
  output logic               rd_writable,
  output logic               rd_uncached
);

  logic [ENTRIES-1:0] v_q, w_q, u_q, g_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      w_q <= '0;
      u_q <= '0;
      g_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        asid_q[i] <= '0;
      end
    end else if (wr_en) begin
      v_q[wr_idx]    <= wr_valid;
      w_q[wr_idx]    <= wr_writable;
      u_q[wr_idx]    <= wr_uncached;
      g_q[wr_idx]    <= wr_global;
      vpn_q[wr_idx]  <= wr_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
      asid_q[wr_idx] <= wr_asid;
    end
  end

  // one comparator per slot
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic page_eq, tag_ok;
    assign page_eq      = (vpn_q[e] == lk_vpn);
    assign tag_ok       = g_q[e] || (asid_q[e] == lk_asid);
    assign match_vec[e] = v_q[e] && page_eq && tag_ok;
  end

  assign rd_pfn      = pfn_q[rd_idx];
  assign rd_writable = w_q[rd_idx];
  assign rd_uncached = u_q[rd_idx];

  // R10: a write lands in the slot on the following edge
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (v_q[$past(wr_idx)] == $past(wr_valid)));

  // R6: an invalid slot never reports a match
  p_invalid_nomatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_vec & ~v_q) == '0));

endmodule

// File: rtl/tlb_first_match.sv
module tlb_first_match #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [ENTRIES-1:0] grant
);

  always_comb begin
    logic seen;
    seen  = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (req[i] && !seen) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
      seen = seen | req[i];
    end
    found = seen;
  end

  // R9: exactly one winner, it is a requester, and the index points at it
  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ($onehot(grant) && ((grant & ~req) == '0) && grant[idx]));

  p_no_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (grant == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 6,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PA_W   = PFN_W + OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic               lk_store,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_valid,
  input  logic               wr_writable,
  input  logic               wr_uncached,
  input  logic               wr_global,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_mod_fault,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_cacheable
);

  localparam int unsigned DIR_W = VA_W - SEG_BITS;

  // reset: asserted at once, released on the clock
  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  seg_e seg;
  logic seg_mapped;
  tlb_seg_decode i_seg (
    .top_bits (lk_vaddr[VA_W-1 -: SEG_BITS]),
    .seg      (seg),
    .mapped   (seg_mapped)
  );

  logic [ENTRIES-1:0] match_vec, grant;
  logic               found;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_writable, hit_uncached;

  tlb_entry_array #(
    .ENTRIES (ENTRIES), .VPN_W (VPN_W), .PFN_W (PFN_W), .ASID_W (ASID_W)
  ) i_array (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_vpn      (wr_vpn),
    .wr_asid     (wr_asid),
    .wr_pfn      (wr_pfn),
    .wr_valid    (wr_valid),
    .wr_writable (wr_writable),
    .wr_uncached (wr_uncached),
    .wr_global   (wr_global),
    .lk_vpn      (lk_vaddr[VA_W-1:OFF_W]),
    .lk_asid     (lk_asid),
    .match_vec   (match_vec),
    .rd_idx      (hit_idx),
    .rd_pfn      (hit_pfn),
    .rd_writable (hit_writable),
    .rd_uncached (hit_uncached)
  );

  tlb_first_match #(.ENTRIES (ENTRIES)) i_pick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .req   (match_vec),
    .found (found),
    .idx   (hit_idx),
    .grant (grant)
  );

  // next-state values of the result
  logic            nx_hit, nx_miss, nx_modf, nx_cach;
  logic [PA_W-1:0] nx_paddr;

  always_comb begin
    if (seg_mapped) begin
      nx_hit   = found;
      nx_miss  = !found;
      nx_paddr = found ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
      nx_cach  = found && !hit_uncached;
      nx_modf  = found && lk_store && !hit_writable;
    end else begin
      nx_hit   = 1'b1;
      nx_miss  = 1'b0;
      nx_paddr = PA_W'(lk_vaddr[DIR_W-1:0]);
      nx_cach  = (seg == SEG_KDIR_C);
      nx_modf  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_miss      <= 1'b0;
      rsp_mod_fault <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit       <= nx_hit;
        rsp_miss      <= nx_miss;
        rsp_mod_fault <= nx_modf;
        rsp_paddr     <= nx_paddr;
        rsp_cacheable <= nx_cach;
      end
    end
  end

  // R11: one-cycle answer, and hold while idle
  p_answer_next_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    lk_valid |=> rsp_valid);
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !lk_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)));
  // R7: a miss carries no address, no cacheability, no fault
  p_miss_clean_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_miss |-> (!rsp_hit && rsp_paddr == '0 && !rsp_cacheable && !rsp_mod_fault));
  // R8: a permission fault only comes with a hit
  p_modf_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_mod_fault |-> rsp_hit);
  // R3: cached direct region always answers with a cacheable hit
  p_kdir_cached_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lk_valid && lk_vaddr[VA_W-1 -: SEG_BITS] == 3'b100) |=> (rsp_hit && rsp_cacheable));
  // R4: uncached direct region always answers with an uncacheable hit
  p_kdir_uncached_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lk_valid && lk_vaddr[VA_W-1 -: SEG_BITS] == 3'b101) |=> (rsp_hit && !rsp_cacheable));

endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_store, wr_en;
  logic [31:0] lk_vaddr;
  logic [5:0]  lk_asid, wr_idx, wr_asid;
  logic [19:0] wr_vpn, wr_pfn;
  logic        wr_valid, wr_writable, wr_uncached, wr_global;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_mod_fault, rsp_cacheable;
  logic [31:0] rsp_paddr;

  always #2 clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk (clk), .rst_n (rst_n),
    .lk_valid (lk_valid), .lk_vaddr (lk_vaddr), .lk_asid (lk_asid), .lk_store (lk_store),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_vpn (wr_vpn), .wr_asid (wr_asid),
    .wr_pfn (wr_pfn), .wr_valid (wr_valid), .wr_writable (wr_writable),
    .wr_uncached (wr_uncached), .wr_global (wr_global),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss),
    .rsp_mod_fault (rsp_mod_fault), .rsp_paddr (rsp_paddr), .rsp_cacheable (rsp_cacheable)
  );

  // behavioural reference table
  bit          m_v [64], m_w [64], m_u [64], m_g [64];
  bit   [19:0] m_vpn [64], m_pfn [64];
  bit   [5:0]  m_asid [64];
  bit          e_valid, e_hit, e_miss, e_modf, e_cach;
  bit   [31:0] e_pa;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string tag);
    checks++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_miss !== e_miss ||
        rsp_mod_fault !== e_modf || rsp_paddr !== e_pa || rsp_cacheable !== e_cach) begin
      fails++;
      $display("FAIL %s: got v%b h%b m%b f%b pa=%h c%b, expected v%b h%b m%b f%b pa=%h c%b",
               tag, rsp_valid, rsp_hit, rsp_miss, rsp_mod_fault, rsp_paddr, rsp_cacheable,
               e_valid, e_hit, e_miss, e_modf, e_pa, e_cach);
    end
  endtask

  // one clock: drive at falling edge, predict, update model, compare after rising edge
  task automatic step(input bit lv, input bit [31:0] va, input bit [5:0] asid, input bit st,
                      input bit we, input int idx, input bit [19:0] vpn, input bit [5:0] wasid,
                      input bit [19:0] pfn, input bit v, input bit w, input bit u, input bit g,
                      input string tag);
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_asid = asid; lk_store = st;
    wr_en = we; wr_idx = idx[5:0]; wr_vpn = vpn; wr_asid = wasid; wr_pfn = pfn;
    wr_valid = v; wr_writable = w; wr_uncached = u; wr_global = g;
    e_valid = lv;
    if (lv) begin
      if (va[31:29] == 3'b100 || va[31:29] == 3'b101) begin
        e_hit = 1; e_miss = 0; e_modf = 0;
        e_pa = {3'b000, va[28:0]};
        e_cach = (va[31:29] == 3'b100);
      end else begin
        int k;
        k = -1;
        for (int i = 0; i < 64; i++)
          if (k < 0 && m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_asid[i] == asid)) k = i;
        if (k < 0) begin
          e_hit = 0; e_miss = 1; e_modf = 0; e_pa = 0; e_cach = 0;
        end else begin
          e_hit = 1; e_miss = 0;
          e_pa = {m_pfn[k], va[11:0]};
          e_cach = !m_u[k];
          e_modf = st && !m_w[k];
        end
      end
    end
    if (we) begin
      m_v[idx] = v; m_w[idx] = w; m_u[idx] = u; m_g[idx] = g;
      m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_asid[idx] = wasid;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic look(input bit [31:0] va, input bit [5:0] asid, input bit st, input string tag);
    step(1, va, asid, st, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic put(input int idx, input bit [19:0] vpn, input bit [5:0] asid, input bit [19:0] pfn,
                     input bit v, input bit w, input bit u, input bit g, input string tag);
    step(0, 0, 0, 0, 1, idx, vpn, asid, pfn, v, w, u, g, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_valid = 0; lk_vaddr = 0; lk_asid = 0; lk_store = 0;
    wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_asid = 0; wr_pfn = 0;
    wr_valid = 0; wr_writable = 0; wr_uncached = 0; wr_global = 0;
    e_valid = 0; e_hit = 0; e_miss = 0; e_modf = 0; e_pa = 0; e_cach = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset state");
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1 check("R1 after release");

    look(32'h0040_0123, 6'd1, 0, "R1 empty table miss");
    look(32'h0040_0123, 6'd1, 0, "R7 miss result fields");
    put(5, 20'h00400, 6'd1, 20'hABCDE, 1, 1, 0, 0, "R2 write slot 5");
    look(32'h0040_0123, 6'd1, 0, "R2 user hit cacheable");
    look(32'h0040_0FFF, 6'd1, 1, "R8 store to writable entry");
    look(32'h0040_0123, 6'd2, 0, "R6 tag mismatch misses");
    idle("R11 hold after lookup");
    idle("R11 hold second idle");

    put(9, 20'h00401, 6'd3, 20'h11111, 1, 0, 1, 1, "R6 write global entry");
    look(32'h0040_1ABC, 6'd7, 0, "R6 global matches any tag");
    look(32'h0040_1ABC, 6'd7, 1, "R8 store to read-only");
    look(32'h0040_1ABC, 6'd3, 0, "R8 load read-only no fault");

    look(32'h8123_4567, 6'd0, 0, "R3 direct cached");
    look(32'h9FFF_FFFF, 6'd0, 1, "R3 direct cached store");
    look(32'hA000_0010, 6'd0, 0, "R4 direct uncached");
    look(32'hBFFF_F000, 6'd9, 1, "R4 direct uncached top");

    look(32'hC000_2ABC, 6'd0, 0, "R5 kernel mapped miss");
    put(63, 20'hC0002, 6'd0, 20'h00777, 1, 1, 0, 1, "R5 write slot 63");
    look(32'hC000_2ABC, 6'd4, 0, "R5 kernel mapped hit");
    look(32'hE000_0000, 6'd0, 0, "R5 upper kernel miss");

    put(20, 20'h00400, 6'd1, 20'h22222, 1, 1, 1, 0, "R9 duplicate at slot 20");
    look(32'h0040_0004, 6'd1, 0, "R9 lowest slot wins");
    put(5, 20'h00400, 6'd1, 20'hABCDE, 0, 1, 0, 0, "R9 clear slot 5");
    look(32'h0040_0004, 6'd1, 0, "R9 next slot wins");
    look(32'h0040_0004, 6'd1, 1, "R6 invalid slot ignored store");

    step(1, 32'h1234_5678, 6'd4, 0, 1, 30, 20'h12345, 6'd4, 20'h0BEEF, 1, 1, 0, 0,
         "R10 lookup with write same cycle");
    look(32'h1234_5678, 6'd4, 0, "R10 write visible next cycle");
    step(1, 32'h1234_5000, 6'd4, 1, 1, 30, 20'h12345, 6'd4, 20'h0BEEF, 0, 0, 0, 0,
         "R10 clear while looking");
    look(32'h1234_5000, 6'd4, 1, "R10 cleared entry misses");
    idle("R11 final hold");

    for (int i = 0; i < 64; i++)
      put(i, 20'h30000 + 20'(i), 6'd2, 20'h40000 + 20'(i), 1, i[0], i[1], 0, "R2 fill table");
    for (int i = 0; i < 64; i += 7)
      look({12'h300, 20'(i) << 12} | 32'h0000_0ABC, 6'd2, i[2], "R2 full table lookup");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule